// File: doc/BRIEF.md
# Phase-Aligned Multi-Channel PWM Generator

This block drives a set of pulse-width-modulated outputs from one clock. Each channel is set by three values, all counted in clock cycles: a period, a high-time width and a start offset. Software reaches the block over a plain 32-bit register bus with word-aligned byte addresses. A write strobe commits data in the cycle it is sampled. A read strobe returns data on the bus one cycle later.

New period and width values are staged. A channel keeps running on its old settings until software issues a global apply command through the control register. The apply copies every channel's staged values into its running copy in the same cycle. It also clears every channel counter at once, so channels whose periods are integer multiples of one another stay phase-locked. After each apply, every channel waits its own offset before it starts its first period. A hold bit in the control register forces all outputs low. The block also holds a version word, an instance number, a fixed identification word, a scratch word and the channel count, so that software can find and check the block.

Top module: `pwm_bank`

## Requirements
- R1: After reset the hold bit is set, so the control register (0x10) reads 0x1. Every output is low, and every staged channel register reads zero.
- R2: Read data appears on `bus_rdata` one cycle after the read strobe. The register at 0x00 reads 0x00010000: major version in bits 31:16, minor in bits 15:8, patch in bits 7:0. The register at 0x04 reads the instance parameter. The register at 0x0C always reads 0x601A3471. The register at 0x14 reads the channel count. Any unmapped address reads zero.
- R3: The scratch word at 0x08 returns the last value written to it. Writes to 0x00, 0x04, 0x0C and 0x14 have no effect.
- R4: Channel n has its period at 0x40+12n, its width at 0x44+12n and its offset at 0x48+12n. Each of these reads back the last value written to it.
- R5: A write to a period or width register leaves every output unchanged until the next apply.
- R6: A write to 0x10 sets the hold bit to bit 0 of the data, and issues an apply when bit 1 is set. Bit 1 always reads back zero. On the clock edge after the write, every channel loads its staged period and width and clears its counter.
- R7: A running channel with period P and width W drives high for the first W cycles of each P-cycle period and low for the rest. If W is P or more, the output stays high. If W is 0, the output stays low.
- R8: A channel whose running period is zero drives low.
- R9: After an apply with no hold, a channel drives low for exactly its offset count of cycles, then starts its period at count zero.
- R10: While the hold bit is set, every output is low and every counter stays at zero. When hold is released, each channel starts at count zero with no offset wait.
- R11: An apply in the middle of a period restarts that period at once. All channels leave the apply edge aligned to count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 8 | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | CHANNELS | One active-high output per channel |

## Verification
The assertions assume that the bus never asserts the read and write strobes in the same cycle. They also assume that the address is word-aligned and that each strobe is held for one cycle per access. The stimulus drives each access from a single task that raises one strobe for one cycle and then drops it, so the bus stays within those limits. A behavioural model in the bench follows every write and predicts each output on every clock. The stimulus covers staged writes in the middle of a period, applies in the middle of a period, zero and oversize widths, nonzero offsets, and the hold bit being set and released while channels are running.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAX_CHANS = 16;

  localparam logic [ADDR_W-1:0] A_VERSION = 8'h00;
  localparam logic [ADDR_W-1:0] A_INST    = 8'h04;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h08;
  localparam logic [ADDR_W-1:0] A_IDENT   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h10;
  localparam logic [ADDR_W-1:0] A_NCHAN   = 8'h14;
  localparam int unsigned CHAN_BASE   = 'h40;
  localparam int unsigned CHAN_STRIDE = 12;

  localparam logic [DATA_W-1:0] IDENT_WORD = 32'h601A3471;

  typedef enum logic [1:0] {
    SLOT_PERIOD = 2'd0,
    SLOT_WIDTH  = 2'd1,
    SLOT_OFFSET = 2'd2
  } chan_slot_e;

  function automatic logic [DATA_W-1:0] version_word(input int unsigned major,
                                                     input int unsigned minor,
                                                     input int unsigned patch);
    return {16'(major), 8'(minor), 8'(patch)};
  endfunction

  function automatic logic [ADDR_W-1:0] chan_addr(input int unsigned ch,
                                                  input chan_slot_e slot);
    return ADDR_W'(CHAN_BASE + CHAN_STRIDE * ch + 4 * int'(slot));
  endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned INST_ID  = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                hold,
  output logic                load_pulse,
  output logic [CNT_W-1:0]    sh_period [CHANNELS],
  output logic [CNT_W-1:0]    sh_width  [CHANNELS],
  output logic [CNT_W-1:0]    sh_offset [CHANNELS]
);
  localparam logic [DATA_W-1:0] VERSION = version_word(1, 0, 0);

  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] rd_next;
  logic              ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= 1'b1;
      load_pulse <= 1'b0;
      scratch_q  <= '0;
    end else begin
      load_pulse <= ctrl_wr && bus_wdata[1];
      if (ctrl_wr) hold <= bus_wdata[0];
      if (bus_wr && bus_addr == A_SCRATCH) scratch_q <= bus_wdata;
    end
  end

  for (genvar n = 0; n < CHANNELS; n++) begin : g_shadow
    logic wr_p, wr_w, wr_o;
    assign wr_p = bus_wr && (bus_addr == chan_addr(n, SLOT_PERIOD));
    assign wr_w = bus_wr && (bus_addr == chan_addr(n, SLOT_WIDTH));
    assign wr_o = bus_wr && (bus_addr == chan_addr(n, SLOT_OFFSET));
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_period[n] <= '0;
        sh_width[n]  <= '0;
        sh_offset[n] <= '0;
      end else begin
        if (wr_p) sh_period[n] <= bus_wdata[CNT_W-1:0];
        if (wr_w) sh_width[n]  <= bus_wdata[CNT_W-1:0];
        if (wr_o) sh_offset[n] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_VERSION: rd_next = VERSION;
      A_INST:    rd_next = DATA_W'(INST_ID);
      A_SCRATCH: rd_next = scratch_q;
      A_IDENT:   rd_next = IDENT_WORD;
      A_CTRL:    rd_next = {{(DATA_W-1){1'b0}}, hold};
      A_NCHAN:   rd_next = DATA_W'(CHANNELS);
      default:   rd_next = '0;
    endcase
    for (int n = 0; n < CHANNELS; n++) begin
      if (bus_addr == chan_addr(n, SLOT_PERIOD)) rd_next[CNT_W-1:0] = sh_period[n];
      if (bus_addr == chan_addr(n, SLOT_WIDTH))  rd_next[CNT_W-1:0] = sh_width[n];
      if (bus_addr == chan_addr(n, SLOT_OFFSET)) rd_next[CNT_W-1:0] = sh_offset[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_next : '0;
  end

  // R6: an apply pulse only follows a control write carrying bit 1
  a_r6_apply_from_write: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[1]));

  // R2: identification word is returned one cycle after its read strobe
  a_r2_ident_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_IDENT) |=> (bus_rdata == IDENT_WORD));

  // R3: scratch keeps its value when not addressed by a write
  a_r3_scratch_kept: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_SCRATCH) |=> $stable(scratch_q));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             load,
  input  logic [CNT_W-1:0] sh_period,
  input  logic [CNT_W-1:0] sh_width,
  input  logic [CNT_W-1:0] sh_offset,
  output logic             pwm_o
);
  logic [CNT_W-1:0] act_p, act_w, cnt, dly;
  logic enabled, in_delay, wrap_evt;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c == p - 1'b1) ? '0 : c + 1'b1;
  endfunction

  function automatic logic pulse_level(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] w);
    return c < w;
  endfunction

  assign enabled  = (act_p != '0);
  assign in_delay = (dly != '0);
  assign wrap_evt = enabled && !in_delay && (cnt == act_p - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_p <= '0;
      act_w <= '0;
      cnt   <= '0;
      dly   <= '0;
    end else begin
      if (load) begin
        act_p <= sh_period;
        act_w <= sh_width;
      end
      if (hold) begin
        cnt <= '0;
        dly <= '0;
      end else if (load) begin
        cnt <= '0;
        dly <= sh_offset;
      end else if (!enabled) begin
        cnt <= '0;
        dly <= '0;
      end else if (in_delay) begin
        dly <= dly - 1'b1;
      end else begin
        cnt <= next_count(cnt, act_p);
      end
    end
  end

  assign pwm_o = !hold && enabled && !in_delay && pulse_level(cnt, act_w);

  // R6: apply copies the staged period and width
  a_r6_apply_copies: assert property (@(posedge clk) disable iff (rst)
    load |=> (act_p == $past(sh_period) && act_w == $past(sh_width)));

  // R11: apply without hold restarts the counter at zero
  a_r11_apply_restarts: assert property (@(posedge clk) disable iff (rst)
    (load && !hold) |=> (cnt == '0));

  // R5: running settings change only on an apply
  a_r5_shadow_isolated: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_p) && $stable(act_w)));

  // R7: counter stays inside the running period
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    enabled |-> (cnt < act_p));

  // R7: a wrap returns the counter to zero
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && !hold && !load) |=> (cnt == '0));

  // R9: the offset wait counts down one per cycle
  a_r9_delay_steps: assert property (@(posedge clk) disable iff (rst)
    (in_delay && enabled && !hold && !load) |=> (dly == $past(dly) - 1'b1));

  // R10: hold clears the counter and the offset wait
  a_r10_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0 && dly == '0));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned INST_ID  = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [CHANNELS-1:0] pwm_out
);
  logic             hold, load_pulse;
  logic [CNT_W-1:0] sh_period [CHANNELS];
  logic [CNT_W-1:0] sh_width  [CHANNELS];
  logic [CNT_W-1:0] sh_offset [CHANNELS];

  pwm_bank_regs #(
    .CHANNELS(CHANNELS), .CNT_W(CNT_W), .INST_ID(INST_ID)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hold(hold), .load_pulse(load_pulse),
    .sh_period(sh_period), .sh_width(sh_width), .sh_offset(sh_offset)
  );

  for (genvar n = 0; n < CHANNELS; n++) begin : g_chan
    pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .hold(hold), .load(load_pulse),
      .sh_period(sh_period[n]), .sh_width(sh_width[n]),
      .sh_offset(sh_offset[n]), .pwm_o(pwm_out[n])
    );
  end

  // R10: outputs are quiet while held
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold |-> (pwm_out == '0));

  // R1: nothing drives high in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pwm_out == '0));
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  int m_hold, m_load;
  int sp[NCH], sw[NCH], so[NCH], ap[NCH], aw[NCH], c[NCH], d[NCH];

  always #5 clk = ~clk;

  pwm_bank #(.CHANNELS(NCH)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // Behavioural reference model of the outputs
  always @(posedge clk) begin
    int nl;
    if (rst) begin
      m_hold = 1; m_load = 0;
      for (int k = 0; k < NCH; k++) begin
        sp[k] = 0; sw[k] = 0; so[k] = 0; ap[k] = 0; aw[k] = 0; c[k] = 0; d[k] = 0;
      end
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (m_load != 0) begin ap[k] = sp[k]; aw[k] = sw[k]; end
        if (m_hold != 0) begin c[k] = 0; d[k] = 0; end
        else if (m_load != 0) begin c[k] = 0; d[k] = so[k]; end
        else if (ap[k] == 0) begin c[k] = 0; d[k] = 0; end
        else if (d[k] > 0) d[k] = d[k] - 1;
        else begin c[k] = c[k] + 1; if (c[k] >= ap[k]) c[k] = 0; end
      end
      nl = 0;
      if (bus_wr) begin
        if (bus_addr == 8'h10) begin m_hold = int'(bus_wdata[0]); nl = int'(bus_wdata[1]); end
        for (int k = 0; k < NCH; k++) begin
          if (int'(bus_addr) == 64 + 12*k)     sp[k] = int'(bus_wdata);
          if (int'(bus_addr) == 64 + 12*k + 4) sw[k] = int'(bus_wdata);
          if (int'(bus_addr) == 64 + 12*k + 8) so[k] = int'(bus_wdata);
        end
      end
      m_load = nl;
    end
  end

  function automatic logic [NCH-1:0] model_out();
    logic [NCH-1:0] v = '0;
    for (int k = 0; k < NCH; k++)
      v[k] = (m_hold == 0) && (ap[k] != 0) && (d[k] == 0) && (c[k] < aw[k]);
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (pwm_out !== model_out()) begin
        errors++;
        $display("FAIL %s pwm_out actual %b expected %b at cycle %0d",
                 cur_req, pwm_out, model_out(), cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual %0d cycles expected under 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    // R1 reset state
    cur_req = "R1";
    checks++;
    if (pwm_out !== '0) begin
      errors++; $display("FAIL R1 pwm_out actual %b expected 0", pwm_out);
    end
    rd_check(8'h10, 32'h1, "R1");
    rd_check(8'h40, 32'h0, "R1");
    rd_check(8'h44 + 8'd12, 32'h0, "R1");
    // R2 identification
    cur_req = "R2";
    rd_check(8'h00, 32'h0001_0000, "R2");
    rd_check(8'h04, 32'h0, "R2");
    rd_check(8'h0C, 32'h601A3471, "R2");
    rd_check(8'h14, NCH, "R2");
    rd_check(8'h18, 32'h0, "R2");
    // R3 scratch and read-only words
    cur_req = "R3";
    wr(8'h08, 32'hDEADBEEF);
    rd_check(8'h08, 32'hDEADBEEF, "R3");
    wr(8'h0C, 32'h0);
    rd_check(8'h0C, 32'h601A3471, "R3");
    wr(8'h14, 32'h99);
    rd_check(8'h14, NCH, "R3");
    wr(8'h00, 32'h5);
    rd_check(8'h00, 32'h0001_0000, "R3");
    // R4 channel layout
    cur_req = "R4";
    wr(8'h40, 10); wr(8'h44, 3); wr(8'h48, 0);
    wr(8'h4C, 20); wr(8'h50, 5); wr(8'h54, 4);
    wr(8'h58, 5);  wr(8'h5C, 7); wr(8'h60, 2);
    wr(8'h64, 0);  wr(8'h68, 2); wr(8'h6C, 1);
    rd_check(8'h40, 10, "R4");
    rd_check(8'h50, 5, "R4");
    rd_check(8'h54, 4, "R4");
    rd_check(8'h5C, 7, "R4");
    // R10 release hold, nothing active yet; R5 staged values not applied
    cur_req = "R5";
    wr(8'h10, 32'h0);
    run(30);
    checks++;
    if (pwm_out !== '0) begin
      errors++; $display("FAIL R5 pwm_out actual %b expected 0", pwm_out);
    end
    // R6 apply, R7 shapes, R9 offsets, R8 zero period on ch3
    cur_req = "R6";
    wr(8'h10, 32'h2);
    rd_check(8'h10, 32'h0, "R6");
    cur_req = "R9";
    run(60);
    cur_req = "R7";
    run(40);
    // R5 staged change mid-run must not show
    cur_req = "R5";
    wr(8'h40, 6); wr(8'h44, 2);
    run(17);
    // R11 apply mid-period
    cur_req = "R11";
    wr(8'h10, 32'h2);
    run(70);
    // R8 zero period disables ch1; R7 zero width on ch3
    cur_req = "R8";
    wr(8'h4C, 0); wr(8'h64, 4); wr(8'h68, 0);
    wr(8'h10, 32'h2);
    rd_check(8'h4C, 32'h0, "R8");
    run(40);
    // R10 hold mid-run then release
    cur_req = "R10";
    wr(8'h64, 4); wr(8'h68, 3);
    run(5);
    wr(8'h10, 32'h1);
    run(12);
    checks++;
    if (pwm_out !== '0) begin
      errors++; $display("FAIL R10 pwm_out actual %b expected 0", pwm_out);
    end
    wr(8'h10, 32'h3);
    run(10);
    wr(8'h10, 32'h0);
    run(40);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule